// File: doc/BRIEF.md
# SDRAM Read Termination and Turnaround Sequencer

This block sits in the command path of an SDR SDRAM controller and decides what follows a READ burst. A host request names the bank and column to read, the burst length, the last data element it actually wants, whether the burst should be closed with an early PRECHARGE, whether the READ carries auto precharge, and whether a single-word WRITE should follow. The sequencer issues the READ in the cycle the request is accepted. It places the PRECHARGE so that the burst ends exactly on the wanted element, whatever the CAS latency. After a PRECHARGE it keeps the bank closed for the row-precharge time.

When a WRITE follows, the sequencer raises DQM two cycles ahead of each unwanted read element that would still reach the bus. It leaves a guard cycle, plus an optional extra NOP for slow output turn-off, before driving write data. It enables the data-bus driver only in the write-data cycle. Any cycle with no command drives a NOP. CAS latency, tRP and the extra-NOP choice are configuration inputs.

Top module: `rdterm_seq`

## Requirements
- R1: With truncation requested, PRECHARGE (cmd code 3, addr bit 10 low, bank of the read) appears k+1 cycles after the READ (cmd code 1) for every CAS latency, where k is the wanted last element clamped to burst length minus one.
- R2: After a PRECHARGE to a bank, the next READ to that bank is issued no sooner than cfg_trp_i cycles after the PRECHARGE, and exactly then if it was waiting. A request to another bank is not delayed.
- R3: A request is refused if it has auto precharge (addr bit 10 of the READ) together with truncation, a full-page burst or a following write, or if it has a write to the same bank as a truncated read. On refusal refuse_o is high in the request cycle and no command is issued.
- R4: A full-page burst (req_bl_i codes 4 to 7; codes 0..3 give 1, 2, 4, 8 elements) with no following write is always ended by a PRECHARGE k+1 cycles after the READ.
- R5: An auto-precharge READ drives addr bit 10 high, issues no PRECHARGE command, and blocks its bank until burst length plus cfg_trp_i cycles after the READ.
- R6: A following WRITE (cmd code 2) is issued CL+k+2+e cycles after the READ, with e the extra-NOP setting, at the write bank and write column.
- R7: With a following write, DQM is high exactly on offsets CL+k-1 up to CL+k-1+e whose masked element (offset+2-CL) lies inside the burst, and is low on the WRITE cycle.
- R8: A burst of one element followed by a write raises DQM on no cycle.
- R9: dq_oe_o is high only in the WRITE cycle, once per write.
- R10: Out of reset and on every cycle without a command, cmd_o is NOP (code 0) with bank and address zero; DQM and dq_oe_o are low after reset.
- R11: A request is accepted only when the sequencer is idle and the read bank, and the write bank if any, are open for commands; the READ is issued in the accepting cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted or refused this cycle |
| req_bank_i | input | BANK_W | Read bank |
| req_col_i | input | COL_W | Read start column |
| req_bl_i | input | 3 | Burst length code |
| req_last_i | input | COL_W | Wanted last element k |
| req_trunc_i | input | 1 | End the burst with an early PRECHARGE |
| req_autopre_i | input | 1 | READ with auto precharge |
| req_wr_i | input | 1 | WRITE follows the read |
| req_wr_bank_i | input | BANK_W | Write bank |
| req_wr_col_i | input | COL_W | Write column |
| cfg_cl_i | input | 2 | CAS latency 1..3 (0 acts as 1) |
| cfg_trp_i | input | TRP_W | Row-precharge time in cycles |
| cfg_extra_nop_i | input | 1 | Insert one more NOP before the WRITE |
| refuse_o | output | 1 | Request refused |
| cmd_o | output | 3 | SDRAM command code |
| bank_o | output | BANK_W | Command bank |
| addr_o | output | ADDR_W | Command address |
| dqm_o | output | 1 | Data mask |
| dq_oe_o | output | 1 | Data-bus drive enable |

## Verification
A corrupted offset counter or latched request moves the PRECHARGE or WRITE to the wrong cycle, or puts DQM on the wrong cycles. That shows at the command pins within the same burst, a few cycles after the READ. A bank timer that is loaded wrongly or never runs down shows only on the next request to that bank, as a READ issued too early or held back too long. The bench therefore issues back-to-back requests to the same bank and to a different bank, and measures the gap between them.

// File: rtl/rdterm_pkg.sv
package rdterm_pkg;
  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_PRE   = 3'd3
  } cmd_e;
endpackage

// File: rtl/rdterm_plan.sv
// Derives the command schedule (offsets from the READ cycle) from a request.
module rdterm_plan #(
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int CNT_W  = COL_W + 3
) (
  input  logic [2:0]        bl_code_i,
  input  logic [COL_W-1:0]  last_i,
  input  logic              trunc_i,
  input  logic              autopre_i,
  input  logic              wr_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  input  logic [BANK_W-1:0] wr_bank_i,
  input  logic [1:0]        cl_i,
  input  logic              extra_i,
  output logic              refuse_o,
  output logic              pre_en_o,
  output logic [CNT_W-1:0]  len_o,
  output logic [CNT_W-1:0]  clv_o,
  output logic [CNT_W-1:0]  pre_off_o,
  output logic [CNT_W-1:0]  wr_off_o,
  output logic [CNT_W-1:0]  mask_lo_o,
  output logic [CNT_W-1:0]  mask_hi_o,
  output logic [CNT_W-1:0]  done_off_o
);
  logic             fullpage;
  logic [CNT_W-1:0] k_raw, k_cl, end_idx, ext;

  always_comb begin
    fullpage = bl_code_i > 3'd3;
    len_o    = fullpage ? (CNT_W'(1) << COL_W) : (CNT_W'(1) << bl_code_i);
    clv_o    = (cl_i == 2'd0) ? CNT_W'(1) : CNT_W'(cl_i);
    ext      = CNT_W'(extra_i);
    k_raw    = CNT_W'(last_i);
    k_cl     = (k_raw > len_o - CNT_W'(1)) ? len_o - CNT_W'(1) : k_raw;
    end_idx  = (trunc_i || wr_i || fullpage) ? k_cl : len_o - CNT_W'(1);

    refuse_o = (autopre_i && (trunc_i || fullpage || wr_i)) ||
               (wr_i && trunc_i && (wr_bank_i == rd_bank_i));

    // precharge lands CL-1 cycles before element k is valid: offset k+1
    pre_en_o   = trunc_i || (fullpage && !wr_i);
    pre_off_o  = end_idx + CNT_W'(1);
    wr_off_o   = clv_o + end_idx + CNT_W'(2) + ext;
    mask_lo_o  = clv_o + end_idx - CNT_W'(1);
    mask_hi_o  = mask_lo_o + ext;
    done_off_o = wr_i ? wr_off_o : clv_o + end_idx;
  end
endmodule

// File: rtl/rdterm_bank_timer.sv
// Per-bank row-precharge hold-off counters.
module rdterm_bank_timer #(
  parameter int BANK_W = 2,
  parameter int TRP_W  = 4,
  localparam int NB    = 1 << BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BANK_W-1:0] load_bank_i,
  input  logic [TRP_W-1:0]  trp_i,
  output logic [NB-1:0]     free_o
);
  logic [TRP_W-1:0] ld_val;
  assign ld_val = (trp_i == '0) ? '0 : trp_i - TRP_W'(1);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [TRP_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  cnt_q <= '0;
      else if (load_i && load_bank_i == BANK_W'(b)) cnt_q <= ld_val;
      else if (cnt_q != '0)                         cnt_q <= cnt_q - TRP_W'(1);
    end
    assign free_o[b] = (cnt_q == '0);
  end
endmodule

// File: rtl/rdterm_sched.sv
// Decodes the current offset into command, address, mask and drive enable.
module rdterm_sched
  import rdterm_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10,
  parameter int CNT_W  = COL_W + 3
) (
  input  logic              active_i,
  input  logic [CNT_W-1:0]  t_i,
  input  logic              pre_en_i,
  input  logic              autopre_i,
  input  logic              wr_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [CNT_W-1:0]  clv_i,
  input  logic [CNT_W-1:0]  pre_off_i,
  input  logic [CNT_W-1:0]  wr_off_i,
  input  logic [CNT_W-1:0]  mask_lo_i,
  input  logic [CNT_W-1:0]  mask_hi_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  input  logic [COL_W-1:0]  rd_col_i,
  input  logic [BANK_W-1:0] wr_bank_i,
  input  logic [COL_W-1:0]  wr_col_i,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dqm_o,
  output logic              dq_oe_o,
  output logic              tload_o,
  output logic [BANK_W-1:0] tload_bank_o
);
  cmd_e cmd;

  always_comb begin
    cmd     = CMD_NOP;
    bank_o  = '0;
    addr_o  = '0;
    dq_oe_o = 1'b0;
    if (active_i) begin
      if (t_i == '0) begin
        cmd                 = CMD_READ;
        bank_o              = rd_bank_i;
        addr_o[COL_W-1:0]   = rd_col_i;
        addr_o[AP_BIT]      = autopre_i;
      end else if (pre_en_i && t_i == pre_off_i) begin
        cmd                 = CMD_PRE;
        bank_o              = rd_bank_i;
      end else if (wr_i && t_i == wr_off_i) begin
        cmd                 = CMD_WRITE;
        bank_o              = wr_bank_i;
        addr_o[COL_W-1:0]   = wr_col_i;
        dq_oe_o             = 1'b1;
      end
    end
    cmd_o = cmd;
  end

  // read masking acts two cycles later; only mask elements that exist
  assign dqm_o = active_i && wr_i && (t_i >= mask_lo_i) && (t_i <= mask_hi_i) &&
                 (t_i + CNT_W'(2) < len_i + clv_i);

  assign tload_o      = (cmd == CMD_PRE) ||
                        (active_i && autopre_i && t_i == len_i);
  assign tload_bank_o = rd_bank_i;
endmodule

// File: rtl/rdterm_seq.sv
module rdterm_seq
  import rdterm_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10,
  parameter int TRP_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [2:0]        req_bl_i,
  input  logic [COL_W-1:0]  req_last_i,
  input  logic              req_trunc_i,
  input  logic              req_autopre_i,
  input  logic              req_wr_i,
  input  logic [BANK_W-1:0] req_wr_bank_i,
  input  logic [COL_W-1:0]  req_wr_col_i,
  input  logic [1:0]        cfg_cl_i,
  input  logic [TRP_W-1:0]  cfg_trp_i,
  input  logic              cfg_extra_nop_i,
  output logic              refuse_o,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dqm_o,
  output logic              dq_oe_o
);
  localparam int NB    = 1 << BANK_W;
  localparam int CNT_W = COL_W + 3;

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BANK_W-1:0] bank_q, wbank_q;
  logic [COL_W-1:0]  col_q, last_q, wcol_q;
  logic [2:0]        bl_q;
  logic [1:0]        cl_q;
  logic              trunc_q, ap_q, wr_q, ext_q;

  logic [BANK_W-1:0] s_bank, s_wbank;
  logic [COL_W-1:0]  s_col, s_last, s_wcol;
  logic [2:0]        s_bl;
  logic [1:0]        s_cl;
  logic              s_trunc, s_ap, s_wr, s_ext;

  // idle: plan from live request; busy: plan from latched request
  assign s_bank  = busy_q ? bank_q  : req_bank_i;
  assign s_wbank = busy_q ? wbank_q : req_wr_bank_i;
  assign s_col   = busy_q ? col_q   : req_col_i;
  assign s_last  = busy_q ? last_q  : req_last_i;
  assign s_wcol  = busy_q ? wcol_q  : req_wr_col_i;
  assign s_bl    = busy_q ? bl_q    : req_bl_i;
  assign s_cl    = busy_q ? cl_q    : cfg_cl_i;
  assign s_trunc = busy_q ? trunc_q : req_trunc_i;
  assign s_ap    = busy_q ? ap_q    : req_autopre_i;
  assign s_wr    = busy_q ? wr_q    : req_wr_i;
  assign s_ext   = busy_q ? ext_q   : cfg_extra_nop_i;

  logic             refuse, pre_en;
  logic [CNT_W-1:0] len, clv, pre_off, wr_off, mask_lo, mask_hi, done_off;

  rdterm_plan #(.COL_W(COL_W), .BANK_W(BANK_W), .CNT_W(CNT_W)) i_plan (
    .bl_code_i (s_bl),
    .last_i    (s_last),
    .trunc_i   (s_trunc),
    .autopre_i (s_ap),
    .wr_i      (s_wr),
    .rd_bank_i (s_bank),
    .wr_bank_i (s_wbank),
    .cl_i      (s_cl),
    .extra_i   (s_ext),
    .refuse_o  (refuse),
    .pre_en_o  (pre_en),
    .len_o     (len),
    .clv_o     (clv),
    .pre_off_o (pre_off),
    .wr_off_o  (wr_off),
    .mask_lo_o (mask_lo),
    .mask_hi_o (mask_hi),
    .done_off_o(done_off)
  );

  logic              tload;
  logic [BANK_W-1:0] tload_bank;
  logic [NB-1:0]     free;

  rdterm_bank_timer #(.BANK_W(BANK_W), .TRP_W(TRP_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tload),
    .load_bank_i(tload_bank),
    .trp_i      (cfg_trp_i),
    .free_o     (free)
  );

  logic banks_ok, start, active;
  logic [CNT_W-1:0] t;

  assign banks_ok    = free[req_bank_i] && (!req_wr_i || free[req_wr_bank_i]);
  assign req_ready_o = !busy_q && (refuse || banks_ok);
  assign refuse_o    = !busy_q && req_valid_i && refuse;
  assign start       = !busy_q && req_valid_i && banks_ok && !refuse;
  assign active      = busy_q || start;
  assign t           = busy_q ? cnt_q : '0;

  rdterm_sched #(
    .BANK_W(BANK_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .CNT_W(CNT_W)
  ) i_sched (
    .active_i    (active),
    .t_i         (t),
    .pre_en_i    (pre_en),
    .autopre_i   (s_ap),
    .wr_i        (s_wr),
    .len_i       (len),
    .clv_i       (clv),
    .pre_off_i   (pre_off),
    .wr_off_i    (wr_off),
    .mask_lo_i   (mask_lo),
    .mask_hi_i   (mask_hi),
    .rd_bank_i   (s_bank),
    .rd_col_i    (s_col),
    .wr_bank_i   (s_wbank),
    .wr_col_i    (s_wcol),
    .cmd_o       (cmd_o),
    .bank_o      (bank_o),
    .addr_o      (addr_o),
    .dqm_o       (dqm_o),
    .dq_oe_o     (dq_oe_o),
    .tload_o     (tload),
    .tload_bank_o(tload_bank)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      bank_q  <= '0;
      wbank_q <= '0;
      col_q   <= '0;
      last_q  <= '0;
      wcol_q  <= '0;
      bl_q    <= '0;
      cl_q    <= '0;
      trunc_q <= 1'b0;
      ap_q    <= 1'b0;
      wr_q    <= 1'b0;
      ext_q   <= 1'b0;
    end else if (start) begin
      busy_q  <= 1'b1;
      cnt_q   <= CNT_W'(1);
      bank_q  <= req_bank_i;
      wbank_q <= req_wr_bank_i;
      col_q   <= req_col_i;
      last_q  <= req_last_i;
      wcol_q  <= req_wr_col_i;
      bl_q    <= req_bl_i;
      cl_q    <= cfg_cl_i;
      trunc_q <= req_trunc_i;
      ap_q    <= req_autopre_i;
      wr_q    <= req_wr_i;
      ext_q   <= cfg_extra_nop_i;
    end else if (busy_q) begin
      if (cnt_q == done_off) busy_q <= 1'b0;
      else                   cnt_q  <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rdterm_seq_chk.sv
module rdterm_seq_chk
  import rdterm_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 12,
  parameter int TRP_W  = 4,
  localparam int NB    = 1 << BANK_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [TRP_W-1:0]  cfg_trp_i,
  input logic              refuse_o,
  input logic [2:0]        cmd_o,
  input logic [BANK_W-1:0] bank_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              dqm_o,
  input logic              dq_oe_o
);
  // independent model of the precharge hold-off, seen only from the pins
  logic [TRP_W-1:0] hold_q [NB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NB; b++) hold_q[b] <= '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (cmd_o == CMD_PRE && bank_o == BANK_W'(b))
          hold_q[b] <= (cfg_trp_i == '0) ? '0 : cfg_trp_i - TRP_W'(1);
        else if (hold_q[b] != '0)
          hold_q[b] <= hold_q[b] - TRP_W'(1);
      end
    end
  end

  p_trp_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_READ || cmd_o == CMD_WRITE) |-> hold_q[bank_o] == '0);

  p_refuse_silent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refuse_o |-> cmd_o == CMD_NOP);

  p_write_unmasked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == CMD_WRITE |-> !dqm_o);

  p_oe_on_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> cmd_o == CMD_WRITE);

  p_oe_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |=> !dq_oe_o);

  p_nop_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == CMD_NOP |-> (addr_o == '0 && bank_o == '0 && !dq_oe_o));

  p_read_handshake_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == CMD_READ |-> (req_valid_i && req_ready_o));
endmodule

bind rdterm_seq rdterm_seq_chk #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .TRP_W(TRP_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .cfg_trp_i  (cfg_trp_i),
  .refuse_o   (refuse_o),
  .cmd_o      (cmd_o),
  .bank_o     (bank_o),
  .addr_o     (addr_o),
  .dqm_o      (dqm_o),
  .dq_oe_o    (dq_oe_o)
);

// File: tb/test_rdterm_seq.sv
`timescale 1ns/1ps
module test_rdterm_seq;
  localparam int BANK_W = 2, COL_W = 8, ADDR_W = 12, AP_BIT = 10, TRP_W = 4;
  localparam logic [2:0] C_NOP = 3'd0, C_RD = 3'd1, C_WR = 3'd2, C_PRE = 3'd3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_ready_o;
  logic [BANK_W-1:0] req_bank_i = '0, req_wr_bank_i = '0;
  logic [COL_W-1:0]  req_col_i = '0, req_last_i = '0, req_wr_col_i = '0;
  logic [2:0]        req_bl_i = '0;
  logic              req_trunc_i = 0, req_autopre_i = 0, req_wr_i = 0;
  logic [1:0]        cfg_cl_i = 2'd2;
  logic [TRP_W-1:0]  cfg_trp_i = 4'd2;
  logic              cfg_extra_nop_i = 0;
  logic              refuse_o, dqm_o, dq_oe_o;
  logic [2:0]        cmd_o;
  logic [BANK_W-1:0] bank_o;
  logic [ADDR_W-1:0] addr_o;

  always #2.5 clk_i = ~clk_i;

  rdterm_seq #(.BANK_W(BANK_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .TRP_W(TRP_W))
  i_rdterm_seq (.*);

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [2:0]        tr_cmd  [64];
  logic [BANK_W-1:0] tr_bank [64];
  logic [ADDR_W-1:0] tr_addr [64];
  logic              tr_dqm  [64];
  logic              tr_oe   [64];
  int tr_n;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int find_cmd(logic [2:0] c);
    for (int i = 0; i < tr_n; i++) if (tr_cmd[i] == c) return i;
    return -1;
  endfunction

  function automatic int count_cmd(logic [2:0] c);
    int n = 0;
    for (int i = 0; i < tr_n; i++) if (tr_cmd[i] == c) n++;
    return n;
  endfunction

  function automatic int count_dqm();
    int n = 0;
    for (int i = 0; i < tr_n; i++) if (tr_dqm[i]) n++;
    return n;
  endfunction

  function automatic int first_dqm();
    for (int i = 0; i < tr_n; i++) if (tr_dqm[i]) return i;
    return -1;
  endfunction

  function automatic int count_oe();
    int n = 0;
    for (int i = 0; i < tr_n; i++) if (tr_oe[i]) n++;
    return n;
  endfunction

  task automatic sample(int t);
    tr_cmd[t] = cmd_o; tr_bank[t] = bank_o; tr_addr[t] = addr_o;
    tr_dqm[t] = dqm_o; tr_oe[t] = dq_oe_o;
  endtask

  // drive one request, wait for acceptance, record n cycles from it
  task automatic issue(int bank, int col, int bl, int k, bit tr, bit ap, bit wr,
                       int wbank, int wcol, int cl, bit e, int trp, int n,
                       output int t0, output bit refused);
    @(negedge clk_i);
    req_valid_i = 1; req_bank_i = BANK_W'(bank); req_col_i = COL_W'(col);
    req_bl_i = 3'(bl); req_last_i = COL_W'(k); req_trunc_i = tr; req_autopre_i = ap;
    req_wr_i = wr; req_wr_bank_i = BANK_W'(wbank); req_wr_col_i = COL_W'(wcol);
    cfg_cl_i = 2'(cl); cfg_extra_nop_i = e; cfg_trp_i = TRP_W'(trp);
    #1;
    while (!req_ready_o) begin @(negedge clk_i); #1; end
    t0 = cyc; refused = refuse_o; tr_n = n;
    sample(0);
    for (int t = 1; t < n; t++) begin
      @(negedge clk_i);
      if (t == 1) req_valid_i = 0;
      #1;
      sample(t);
    end
  endtask

  task automatic t_reset();
    @(negedge clk_i); #1;
    chk("R10 reset cmd", int'(cmd_o), 0);
    chk("R10 reset dqm", int'(dqm_o), 0);
    chk("R10 reset oe", int'(dq_oe_o), 0);
    chk("R11 idle ready", int'(req_ready_o), 1);
  endtask

  task automatic t_trunc(int cl);
    int t0; bit rf;
    issue(0, 8'h40, 3, 2, 1, 0, 0, 0, 0, cl, 0, 2, 8, t0, rf);
    chk($sformatf("R1 read at 0 cl%0d", cl), find_cmd(C_RD), 0);
    chk($sformatf("R1 pre offset cl%0d", cl), find_cmd(C_PRE), 3);
    chk("R1 pre a10 low", int'(tr_addr[3][AP_BIT]), 0);
    chk("R10 only two commands", count_cmd(C_NOP), 6);
  endtask

  task automatic t_clamp();
    int t0; bit rf;
    issue(1, 0, 1, 5, 1, 0, 0, 0, 0, 3, 0, 2, 6, t0, rf);
    chk("R1 clamped pre offset", find_cmd(C_PRE), 2);
  endtask

  task automatic t_fullpage();
    int t0; bit rf;
    issue(2, 0, 7, 10, 0, 0, 0, 0, 0, 2, 0, 2, 14, t0, rf);
    chk("R4 fullpage pre offset", find_cmd(C_PRE), 11);
    chk("R4 fullpage pre bank", int'(tr_bank[11]), 2);
  endtask

  task automatic t_trp();
    int ta, tb, tc, td; bit rf;
    issue(1, 0, 3, 1, 1, 0, 0, 0, 0, 2, 0, 6, 6, ta, rf);
    issue(1, 0, 0, 0, 0, 0, 0, 0, 0, 2, 0, 6, 4, tb, rf);
    chk("R2 same bank gap", tb - ta, 8);
    issue(1, 0, 3, 1, 1, 0, 0, 0, 0, 2, 0, 6, 4, tc, rf);
    issue(2, 0, 0, 0, 0, 0, 0, 0, 0, 2, 0, 6, 4, td, rf);
    chk("R2 other bank gap", td - tc, 4);
  endtask

  task automatic t_refuse();
    int t0; bit rf;
    issue(0, 0, 2, 1, 1, 1, 0, 0, 0, 2, 0, 2, 3, t0, rf);
    chk("R3 autopre+trunc refused", int'(rf), 1);
    chk("R3 no command", count_cmd(C_NOP), 3);
    issue(3, 0, 2, 1, 1, 0, 1, 3, 0, 2, 0, 2, 3, t0, rf);
    chk("R3 write to truncated bank refused", int'(rf), 1);
    issue(0, 0, 7, 1, 0, 1, 0, 0, 0, 2, 0, 2, 3, t0, rf);
    chk("R3 fullpage+autopre refused", int'(rf), 1);
    chk("R3 no command fullpage", count_cmd(C_NOP), 3);
  endtask

  task automatic t_autopre();
    int ta, tb; bit rf;
    issue(3, 8'h10, 2, 0, 0, 1, 0, 0, 0, 2, 0, 4, 6, ta, rf);
    chk("R5 read a10 high", int'(tr_addr[0][AP_BIT]), 1);
    chk("R5 no pre command", count_cmd(C_PRE), 0);
    issue(3, 0, 0, 0, 0, 0, 0, 0, 0, 2, 0, 4, 4, tb, rf);
    chk("R5 bank blocked gap", tb - ta, 8);
  endtask

  task automatic t_rw(int cl, bit e);
    int t0, w; bit rf;
    w = cl + 2 + int'(e);
    issue(0, 0, 2, 0, 0, 0, 1, 2, 8'h33, cl, e, 2, w + 2, t0, rf);
    chk($sformatf("R6 write offset cl%0d e%0d", cl, e), find_cmd(C_WR), w);
    chk("R6 write bank", int'(tr_bank[w]), 2);
    chk("R6 write col", int'(tr_addr[w][COL_W-1:0]), 8'h33);
    chk($sformatf("R7 dqm count cl%0d e%0d", cl, e), count_dqm(), 1 + int'(e));
    chk("R7 first dqm", first_dqm(), cl - 1);
    chk("R7 dqm low on write", int'(tr_dqm[w]), 0);
    chk("R9 oe count", count_oe(), 1);
    chk("R9 oe on write", int'(tr_oe[w]), 1);
  endtask

  task automatic t_mask_clip();
    int t0; bit rf;
    issue(0, 0, 1, 0, 0, 0, 1, 1, 0, 2, 1, 2, 8, t0, rf);
    chk("R7 mask limited to burst", count_dqm(), 1);
    chk("R7 mask position", first_dqm(), 1);
  endtask

  task automatic t_bl1();
    int t0; bit rf;
    issue(0, 0, 0, 0, 0, 0, 1, 3, 0, 3, 1, 2, 8, t0, rf);
    chk("R8 burst one no dqm", count_dqm(), 0);
    chk("R6 burst one write offset", find_cmd(C_WR), 6);
  endtask

  task automatic t_rw_long();
    int t0; bit rf;
    issue(0, 0, 3, 3, 1, 0, 1, 1, 0, 2, 1, 2, 10, t0, rf);
    chk("R1 pre with write", find_cmd(C_PRE), 4);
    chk("R6 write after pre", find_cmd(C_WR), 8);
    chk("R7 dqm count long", count_dqm(), 2);
    chk("R7 first dqm long", first_dqm(), 4);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_trunc(1); t_trunc(2); t_trunc(3);
    t_clamp();
    t_fullpage();
    t_trp();
    t_refuse();
    t_autopre();
    t_rw(3, 0); t_rw(3, 1); t_rw(1, 0); t_rw(2, 1);
    t_mask_clip();
    t_bl1();
    t_rw_long();
    repeat (4) @(negedge clk_i);
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule